// File: doc/BRIEF.md
# Dual 8-bit Timer with Sticky Flags

The block holds two independent 8-bit up-counters, called the high half and the low half. Each half has its own compare register. Each counter advances by one on every cycle in which its count strobe is high.

A single 8-bit control/status byte on a simple register bus reports two sticky events per half: counter wrap and compare match. The same byte holds, per half, an enable that gates the wrap interrupt and a select bit that makes a compare match restart the counter.

The event flags can only be cleared by software, and only by a write of 0 that follows a read in which the flag was seen as 1. A write of 1 to a flag does nothing. This stops a stray write from clearing an event that software has not yet seen. The bus is combinational on read and registered on write, with a 3-bit address.

Top module: `dual_timer_flags`

## Requirements
- R1: After reset the status byte (address 0) reads 0x00, both counters (addresses 3 = high, 4 = low) read 0x00, and both compare registers (addresses 1 = high, 2 = low) read 0xFF.
- R2: Status byte layout, bit 7 down to bit 0: high wrap flag, high match flag, high wrap-interrupt enable, high restart select, low wrap flag, low match flag, low wrap-interrupt enable, low restart select.
- R3: A counter increments by one on each cycle with its count strobe high and holds its value otherwise; its value is readable at its address.
- R4: A wrap flag sets on a count strobe that takes its counter from 0xFF to 0x00.
- R5: A match flag sets on a count strobe taken while its counter equals its compare register.
- R6: With restart select 1, a strobe taken on a match loads the counter with 0x00; with restart select 0 the counter keeps counting up through 0xFF.
- R7: Writing 1 to a flag bit (7, 6, 3, 2) leaves that flag unchanged; software cannot set a flag.
- R8: A flag clears only on a status write with 0 in its bit after a status read that returned that flag as 1. Any status write uses up the armed state from that read. A write of 0 without that read leaves the flag set.
- R9: When hardware sets a flag in the same cycle as a clearing write, the flag ends up set.
- R10: Each wrap interrupt output is high exactly when its wrap flag and its enable are both 1, and stays high until a status write changes one of them.
- R11: Enable and restart-select bits (5, 4, 1, 0) and both compare registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | 0 status, 1/2 compare high/low, 3/4 counter high/low |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data, combinational |
| cnt_en_hi_i | input | 1 | Count strobe, high half |
| cnt_en_lo_i | input | 1 | Count strobe, low half |
| irq_ovf_hi_o | output | 1 | Wrap interrupt, high half |
| irq_ovf_lo_o | output | 1 | Wrap interrupt, low half |

## Verification
Two functions can fall in the same cycle: a hardware flag set from a count strobe, and a software clearing write to the status byte. The bench forces this on purpose. It first reads a set match flag to arm it. It then moves the compare register onto the counter's current value and issues the zero write in the very cycle the strobe matches. A later read must still show the flag set. Random traffic mixes reads, writes and strobes so that reads racing strobes and writes racing wraps keep recurring. Every read and every interrupt level is compared against a cycle-step reference model.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  typedef enum logic [2:0] {
    A_STAT   = 3'd0,
    A_CMP_HI = 3'd1,
    A_CMP_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_CNT_LO = 3'd4
  } dtf_addr_e;

  // bit offsets inside one half's nibble of the status byte
  localparam int unsigned BIT_CS  = 0;
  localparam int unsigned BIT_IE  = 1;
  localparam int unsigned BIT_CMF = 2;
  localparam int unsigned BIT_OVF = 3;
  localparam int unsigned HALF_W  = 4;
  localparam int unsigned N_HALF  = 2;
endpackage

// File: rtl/dtf_counter.sv
module dtf_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter logic [CNT_W-1:0] CMP_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_sel_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_evt_o,
  output logic             ovf_evt_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             match;

  assign match       = (cnt_q == cmp_q);
  assign match_evt_o = en_i & match;
  assign ovf_evt_o   = en_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= (clr_sel_i && match) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= CMP_RST;
    else if (cmp_we_i) cmp_q <= cmp_wdata_i;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/dtf_flag.sv
module dtf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic arm_o
);
  logic flag_q, arm_q, clr;

  assign clr = wr_i & ~wbit_i & arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr);   // hardware set wins
      if (wr_i)                arm_q <= 1'b0;
      else if (rd_i && flag_q) arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/dual_timer_flags.sv
module dual_timer_flags
  import dtf_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter logic [CNT_W-1:0] CMP_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  input  logic             cnt_en_hi_i,
  input  logic             cnt_en_lo_i,
  output logic             irq_ovf_hi_o,
  output logic             irq_ovf_lo_o
);
  localparam int unsigned STAT_W = N_HALF * HALF_W;

  logic                          stat_wr, stat_rd;
  logic [N_HALF-1:0]             en, ie_q, cs_q;
  logic [N_HALF-1:0]             ovf_f, cmp_f, ovf_arm, cmp_arm, ovf_evt, match_evt;
  logic [N_HALF-1:0][CNT_W-1:0]  cnt, cmp;
  logic [STAT_W-1:0]             stat;

  assign stat_wr = bus_sel_i &  bus_we_i & (bus_addr_i == A_STAT);
  assign stat_rd = bus_sel_i & ~bus_we_i & (bus_addr_i == A_STAT);
  assign en      = {cnt_en_hi_i, cnt_en_lo_i};

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    localparam int unsigned B = h * HALF_W;
    localparam logic [2:0] CMP_ADDR = (h == 1) ? A_CMP_HI : A_CMP_LO;

    dtf_counter #(.CNT_W(CNT_W), .CMP_RST(CMP_RST)) i_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en[h]),
      .clr_sel_i   (cs_q[h]),
      .cmp_we_i    (bus_sel_i & bus_we_i & (bus_addr_i == CMP_ADDR)),
      .cmp_wdata_i (bus_wdata_i),
      .cnt_o       (cnt[h]),
      .cmp_o       (cmp[h]),
      .match_evt_o (match_evt[h]),
      .ovf_evt_o   (ovf_evt[h])
    );

    dtf_flag i_ovf (
      .clk_i (clk_i), .rst_ni (rst_ni), .set_i (ovf_evt[h]),
      .rd_i  (stat_rd), .wr_i (stat_wr), .wbit_i (bus_wdata_i[B+BIT_OVF]),
      .flag_o (ovf_f[h]), .arm_o (ovf_arm[h])
    );

    dtf_flag i_cmf (
      .clk_i (clk_i), .rst_ni (rst_ni), .set_i (match_evt[h]),
      .rd_i  (stat_rd), .wr_i (stat_wr), .wbit_i (bus_wdata_i[B+BIT_CMF]),
      .flag_o (cmp_f[h]), .arm_o (cmp_arm[h])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ie_q[h] <= 1'b0;
        cs_q[h] <= 1'b0;
      end else if (stat_wr) begin
        ie_q[h] <= bus_wdata_i[B+BIT_IE];
        cs_q[h] <= bus_wdata_i[B+BIT_CS];
      end
    end

    assign stat[B+BIT_OVF] = ovf_f[h];
    assign stat[B+BIT_CMF] = cmp_f[h];
    assign stat[B+BIT_IE]  = ie_q[h];
    assign stat[B+BIT_CS]  = cs_q[h];
  end

  always_comb begin
    unique case (bus_addr_i)
      A_STAT:   bus_rdata_o = CNT_W'(stat);
      A_CMP_HI: bus_rdata_o = cmp[1];
      A_CMP_LO: bus_rdata_o = cmp[0];
      A_CNT_HI: bus_rdata_o = cnt[1];
      A_CNT_LO: bus_rdata_o = cnt[0];
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_ovf_hi_o = ovf_f[1] & ie_q[1];
  assign irq_ovf_lo_o = ovf_f[0] & ie_q[0];
endmodule

// File: rtl/dual_timer_flags_chk.sv
module dual_timer_flags_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  irq_ovf_hi_o,
  input logic                  irq_ovf_lo_o,
  input logic                  stat_wr,
  input logic [1:0]            en,
  input logic [1:0]            cs_q,
  input logic [1:0]            ovf_f,
  input logic [1:0]            cmp_f,
  input logic [1:0]            ovf_arm,
  input logic [1:0]            cmp_arm,
  input logic [1:0]            ovf_evt,
  input logic [1:0]            match_evt,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic [1:0][CNT_W-1:0] cmp
);
  logic [3:0] flags, arms, sets;
  assign flags = {ovf_f, cmp_f};
  assign arms  = {ovf_arm, cmp_arm};
  assign sets  = {ovf_evt, match_evt};

  AST_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(sets)) == 4'b0)); // R7

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flags & $past(flags) & ~$past(arms)) == 4'b0)); // R8

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flags & $past(sets)) == 4'b0)); // R9

  AST_RESTART_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en[1] && cs_q[1] && cnt[1] == cmp[1]) |=> (cnt[1] == '0)); // R6

  AST_RESTART_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en[0] && cs_q[0] && cnt[0] == cmp[0]) |=> (cnt[0] == '0)); // R6

  AST_HOLD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en[1] |=> $stable(cnt[1])); // R3

  AST_HOLD_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en[0] |=> $stable(cnt[0])); // R3

  AST_IRQ_HOLD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ovf_hi_o && !stat_wr) |=> irq_ovf_hi_o); // R10

  AST_IRQ_HOLD_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ovf_lo_o && !stat_wr) |=> irq_ovf_lo_o); // R10
endmodule

bind dual_timer_flags dual_timer_flags_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_ovf_hi_o (irq_ovf_hi_o),
  .irq_ovf_lo_o (irq_ovf_lo_o),
  .stat_wr      (stat_wr),
  .en           (en),
  .cs_q         (cs_q),
  .ovf_f        (ovf_f),
  .cmp_f        (cmp_f),
  .ovf_arm      (ovf_arm),
  .cmp_arm      (cmp_arm),
  .ovf_evt      (ovf_evt),
  .match_evt    (match_evt),
  .cnt          (cnt),
  .cmp          (cmp)
);

// File: tb/test_dual_timer_flags.sv
module test_dual_timer_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, en_hi = 1'b0, en_lo = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_hi, irq_lo;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model, index 1 = high half, 0 = low half
  bit [7:0] m_cnt [2];
  bit [7:0] m_cmp [2];
  bit m_fo [2], m_fc [2], m_ao [2], m_ac [2], m_ie [2], m_cs [2];

  always #2 clk = ~clk;  // 250 MHz

  dual_timer_flags i_dual_timer_flags (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cnt_en_hi_i(en_hi), .cnt_en_lo_i(en_lo),
    .irq_ovf_hi_o(irq_hi), .irq_ovf_lo_o(irq_lo)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic bit [7:0] m_read(input bit [2:0] a);
    case (a)
      3'd0: return {m_fo[1], m_fc[1], m_ie[1], m_cs[1], m_fo[0], m_fc[0], m_ie[0], m_cs[0]};
      3'd1: return m_cmp[1];
      3'd2: return m_cmp[0];
      3'd3: return m_cnt[1];
      3'd4: return m_cnt[0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic void m_reset();
    for (int h = 0; h < 2; h++) begin
      m_cnt[h] = 0; m_cmp[h] = 8'hFF;
      m_fo[h] = 0; m_fc[h] = 0; m_ao[h] = 0; m_ac[h] = 0; m_ie[h] = 0; m_cs[h] = 0;
    end
  endfunction

  function automatic void m_step(input bit s, input bit w_e, input bit [2:0] a,
                                 input bit [7:0] d, input bit eh, input bit el);
    bit w, r;
    w = s && w_e && a == 0;
    r = s && !w_e && a == 0;
    for (int h = 0; h < 2; h++) begin
      bit e, so, sc;
      int bo, bc;
      e  = (h == 1) ? eh : el;
      so = e && m_cnt[h] == 8'hFF;
      sc = e && m_cnt[h] == m_cmp[h];
      bo = 4 * h + 3;
      bc = 4 * h + 2;
      if (e) m_cnt[h] = (m_cs[h] && sc) ? 8'h00 : m_cnt[h] + 8'd1;
      if (w) begin
        m_fo[h] = so || (m_fo[h] && !(!d[bo] && m_ao[h]));
        m_fc[h] = sc || (m_fc[h] && !(!d[bc] && m_ac[h]));
        m_ao[h] = 0; m_ac[h] = 0;
        m_ie[h] = d[4*h+1]; m_cs[h] = d[4*h];
      end else begin
        if (r && m_fo[h]) m_ao[h] = 1;
        if (r && m_fc[h]) m_ac[h] = 1;
        m_fo[h] = m_fo[h] || so;
        m_fc[h] = m_fc[h] || sc;
      end
      if (s && w_e && a == ((h == 1) ? 3'd1 : 3'd2)) m_cmp[h] = d;
    end
  endfunction

  task automatic op(input bit s, input bit w_e, input bit [2:0] a, input bit [7:0] d,
                    input bit eh, input bit el, input string tag);
    @(negedge clk);
    sel = s; we = w_e; addr = a; wdata = d; en_hi = eh; en_lo = el;
    #1;
    if (s && !w_e) chk(tag, rdata, m_read(a));
    chk("R10 irq_hi", irq_hi, m_fo[1] && m_ie[1]);
    chk("R10 irq_lo", irq_lo, m_fo[0] && m_ie[0]);
    @(posedge clk);
    m_step(s, w_e, a, d, eh, el);
  endtask

  task automatic rd(input bit [2:0] a, input string tag);
    op(1, 0, a, 8'h00, 0, 0, tag);
  endtask

  task automatic wr(input bit [2:0] a, input bit [7:0] d, input string tag);
    op(1, 1, a, d, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, "R1 status"); chk("R1 status const", rdata, 8'h00);
    rd(1, "R1 cmp_hi"); chk("R1 cmp_hi const", rdata, 8'hFF);
    rd(2, "R1 cmp_lo");
    rd(3, "R1 cnt_hi"); rd(4, "R1 cnt_lo");

    // R11 control bits and compare registers read back
    wr(0, 8'h33, "R11"); rd(0, "R11 status"); chk("R11 const", rdata, 8'h33);
    wr(0, 8'h00, "R11"); wr(1, 8'h10, "R11"); rd(1, "R11 cmp_hi");
    wr(2, 8'hA5, "R11"); rd(2, "R11 cmp_lo");

    // R3 counting and holding
    for (int i = 0; i < 5; i++) op(0, 0, 0, 0, 1, 0, "R3");
    op(0, 0, 0, 0, 0, 0, "R3");
    rd(3, "R3 cnt_hi"); chk("R3 const", rdata, 8'h05);
    rd(4, "R3 cnt_lo hold");

    // R5 R6 match with restart select on high half
    wr(0, 8'h10, "R6"); wr(1, 8'h07, "R5");
    for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 1, 0, "R6");
    rd(3, "R6 cnt_hi restarted"); chk("R6 const", rdata, 8'h00);
    rd(0, "R5 status"); chk("R5 match flag bit6", rdata[6], 1'b1);

    // R4 wrap on low half (compare 0xFF also matches on the same strobe)
    wr(2, 8'hFF, "R4");
    for (int i = 0; i < 256; i++) op(0, 0, 0, 0, 0, 1, "R4");
    rd(0, "R4 status"); chk("R4 wrap flag bit3", rdata[3], 1'b1);
    rd(4, "R4 cnt_lo"); chk("R4 cnt_lo const", rdata, 8'h00);

    // R7 writes of 1 do not set or clear flags
    wr(0, 8'hCC, "R7"); rd(0, "R7 status"); chk("R7 ovf_hi stays 0", rdata[7], 1'b0);

    // R8 clear protocol (read above armed flags, write below consumes)
    wr(0, 8'hCC, "R8"); wr(0, 8'h00, "R8 no read"); rd(0, "R8 still set");
    chk("R8 flag kept", rdata[6], 1'b1);
    wr(0, 8'h00, "R8 clear"); rd(0, "R8 cleared"); chk("R8 const", rdata, 8'h00);

    // R10 interrupt on low half
    wr(0, 8'h02, "R10");
    for (int i = 0; i < 256; i++) op(0, 0, 0, 0, 0, 1, "R10");
    for (int i = 0; i < 4; i++) op(0, 0, 0, 0, 0, 0, "R10 hold");
    chk("R10 irq_lo high", irq_lo, 1'b1);
    rd(0, "R10 arm"); wr(0, 8'h02, "R10 clear");
    op(0, 0, 0, 0, 0, 0, "R10");
    chk("R10 irq_lo low", irq_lo, 1'b0);
    wr(0, 8'h00, "R10"); rd(0, "R10 status");

    // R9 set wins over clearing write
    wr(2, m_cnt[0], "R9"); op(0, 0, 0, 0, 0, 1, "R9");
    rd(0, "R9 arm"); chk("R9 match flag set", rdata[2], 1'b1);
    wr(2, m_cnt[0], "R9");
    op(1, 1, 0, 8'h00, 0, 1, "R9 collide");
    rd(0, "R9 status"); chk("R9 flag survives", rdata[2], 1'b1);

    // R2 random traffic, layout judged by model
    for (int i = 0; i < 4000; i++) begin
      bit s, w_e;
      bit [2:0] a;
      bit [7:0] d;
      s   = ($urandom % 4) != 0;
      w_e = ($urandom % 3) == 0;
      a   = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom % 6);
      d   = (($urandom % 2) == 0) ? 8'($urandom) & 8'h33 : 8'($urandom);
      op(s, w_e, a, d, ($urandom % 2) == 0, ($urandom % 3) != 0, "R2 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule